// File: doc/BRIEF.md
# Interrupt Destination Bitmask Resolver

This block takes an interprocessor interrupt command and turns it into a one-hot-per-unit bitmask that names the local interrupt units the command must reach. It holds no unit state of its own. Every unit's physical ID, 8-bit logical address, 4-bit logical format code and enable flag arrive on flat input buses. The unit that issues the command is identified by its table index. A destination shorthand can override the addressed target: the sender alone, every unit, or every unit except the sender.

The addressed target can be one of three kinds. In physical mode it is a single physical ID, or the broadcast value. In logical mode each unit compares the destination against its own logical address, and it does so in flat or cluster form. For lowest-priority delivery the mask is cut down to its lowest-indexed member. An INIT de-assert command reaches no unit. For that command the block instead reports, on a separate mask, the units whose arbitration ID must be loaded from their physical ID. The result is registered and appears with a one-cycle strobe.

Top module: `irqr_top`

## Requirements
- R1: Command fields are taken from fixed positions. In `cmd_lo`: vector [7:0], delivery mode [10:8], logical-mode flag bit 11, level bit 14, trigger bit 15, shorthand [19:18]. In `cmd_hi`: destination [31:24]. All other bits are ignored. `tgt_vector` and `tgt_mode` return the vector and delivery mode of the last accepted request.
- R2: With shorthand 0 and physical mode (bit 11 = 0), destination 0xFF selects every enabled unit.
- R3: With shorthand 0, physical mode and any destination other than 0xFF, the lowest-indexed enabled unit whose ID equals the destination is selected. If there is no such unit, the mask is empty.
- R4: In logical mode, a unit with format 0xF is selected when the destination ANDed with its logical address is nonzero.
- R5: In logical mode, a unit with format 0x0 is selected when bits [7:4] of the destination and of its logical address are equal and bits [3:0] of the two share at least one set bit.
- R6: In logical mode, a unit whose format is neither 0xF nor 0x0 is never selected.
- R7: The shorthand codes are: 1 selects only the sender (`self_idx`), 2 selects all enabled units, and 3 selects all enabled units other than the sender.
- R8: A unit whose `unit_en` bit is 0 never appears in either output mask.
- R9: Delivery mode 1 (lowest priority) keeps only the lowest-indexed set bit of the mask computed from R2–R7.
- R10: Delivery mode 5 with level 0 and trigger 1 produces an empty `tgt_mask`. The computed selection is reported on `arb_mask`. Every other command gives `arb_mask` = 0.
- R11: Reset clears all outputs. `tgt_valid` is high exactly in the cycle after a cycle with `req_valid` high, and the outputs from that request appear in the same cycle. Without a request, the masks, vector and mode hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Command present this cycle |
| cmd_lo | input | 32 | Low command word |
| cmd_hi | input | 32 | High command word (destination in [31:24]) |
| self_idx | input | IDX_W | Table index of the sending unit |
| unit_id | input | NUM_UNITS*8 | Physical ID per unit, unit i at [8i+7:8i] |
| unit_ldest | input | NUM_UNITS*8 | Logical address per unit |
| unit_fmt | input | NUM_UNITS*4 | Logical format code per unit |
| unit_en | input | NUM_UNITS | Unit present and enabled |
| tgt_valid | output | 1 | Result strobe |
| tgt_mask | output | NUM_UNITS | Units that receive the interrupt |
| arb_mask | output | NUM_UNITS | Units that load arbitration ID from physical ID |
| tgt_vector | output | 8 | Vector of the resolved command |
| tgt_mode | output | 3 | Delivery mode of the resolved command |

## Verification
Two functions can act on a single command in the same cycle.

The first pair is shorthand exclusion and the lowest-priority reduction. Sending "all but self" in lowest-priority mode from a unit that is the lowest enabled index forces the reduction to act on the mask that is already trimmed. The expected single bit is therefore the next enabled unit, not the sender.

The second pair is the INIT de-assert diversion and the shorthand or addressing logic. The diverted mask must equal what a fixed-mode command would have selected, while `tgt_mask` stays empty.

Both interactions are swept across every destination value, both addressing modes, all four shorthands and three unit tables. Each result is compared with a mask computed bit by bit in the bench.

// File: rtl/irqr_pkg.sv
package irqr_pkg;

    localparam int DEST_W = 8;
    localparam int VEC_W  = 8;
    localparam int FMT_W  = 4;

    localparam logic [DEST_W-1:0] DEST_BCAST  = 8'hFF;
    localparam logic [FMT_W-1:0]  FMT_FLAT    = 4'hF;
    localparam logic [FMT_W-1:0]  FMT_CLUSTER = 4'h0;

    typedef enum logic [1:0] {
        SH_NONE   = 2'd0,
        SH_SELF   = 2'd1,
        SH_ALL    = 2'd2,
        SH_OTHERS = 2'd3
    } shorthand_e;

    typedef enum logic [2:0] {
        DM_FIXED  = 3'd0,
        DM_LOWEST = 3'd1,
        DM_SMI    = 3'd2,
        DM_RSVD   = 3'd3,
        DM_NMI    = 3'd4,
        DM_INIT   = 3'd5,
        DM_START  = 3'd6,
        DM_EXTINT = 3'd7
    } dmode_e;

    typedef struct packed {
        shorthand_e        sh;
        logic [DEST_W-1:0] dest;
        logic              logical;
        dmode_e            mode;
        logic [VEC_W-1:0]  vec;
        logic              level;
        logic              trig;
    } cmd_t;

    function automatic cmd_t decode_cmd(input logic [31:0] lo, input logic [31:0] hi);
        cmd_t c;
        c.sh      = shorthand_e'(lo[19:18]);
        c.dest    = hi[31:24];
        c.logical = lo[11];
        c.mode    = dmode_e'(lo[10:8]);
        c.vec     = lo[7:0];
        c.level   = lo[14];
        c.trig    = lo[15];
        return c;
    endfunction

    function automatic logic logical_hit(input logic [DEST_W-1:0] dest,
                                         input logic [DEST_W-1:0] ld,
                                         input logic [FMT_W-1:0]  fmt);
        if (fmt == FMT_FLAT)
            return |(dest & ld);
        else if (fmt == FMT_CLUSTER)
            return (dest[7:4] == ld[7:4]) && (|(dest[3:0] & ld[3:0]));
        else
            return 1'b0;
    endfunction

    function automatic logic is_arb_sync(input cmd_t c);
        return (c.mode == DM_INIT) && !c.level && c.trig;
    endfunction

endpackage

// File: rtl/irqr_unit_match.sv
module irqr_unit_match
    import irqr_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [DEST_W-1:0]   dest,
    input  logic [N*DEST_W-1:0] unit_id,
    input  logic [N*DEST_W-1:0] unit_ldest,
    input  logic [N*FMT_W-1:0]  unit_fmt,
    input  logic [N-1:0]        unit_en,
    output logic [N-1:0]        phys_hit,
    output logic [N-1:0]        log_hit
);

    for (genvar i = 0; i < N; i++) begin : g_unit
        logic [DEST_W-1:0] id_i;
        logic [DEST_W-1:0] ld_i;
        logic [FMT_W-1:0]  fmt_i;

        assign id_i  = unit_id[i*DEST_W +: DEST_W];
        assign ld_i  = unit_ldest[i*DEST_W +: DEST_W];
        assign fmt_i = unit_fmt[i*FMT_W +: FMT_W];

        assign phys_hit[i] = unit_en[i] && (id_i == dest);
        assign log_hit[i]  = unit_en[i] && logical_hit(dest, ld_i, fmt_i);
    end

endmodule

// File: rtl/irqr_first_set.sv
module irqr_first_set #(
    parameter int N = 8
) (
    input  logic [N-1:0] vec_in,
    output logic [N-1:0] vec_out
);

    localparam logic [N-1:0] ONE = N'(1);

    assign vec_out = vec_in & (~vec_in + ONE);

endmodule

// File: rtl/irqr_scope.sv
module irqr_scope
    import irqr_pkg::*;
#(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  shorthand_e       sh,
    input  logic [IDX_W-1:0] self_idx,
    input  logic [N-1:0]     unit_en,
    input  logic [N-1:0]     addressed,
    output logic [N-1:0]     scoped
);

    localparam logic [N-1:0] ONE = N'(1);

    logic [N-1:0] self_bit;

    assign self_bit = ONE << self_idx;

    always_comb begin
        unique case (sh)
            SH_NONE:   scoped = addressed;
            SH_SELF:   scoped = self_bit & unit_en;
            SH_ALL:    scoped = unit_en;
            SH_OTHERS: scoped = unit_en & ~self_bit;
            default:   scoped = '0;
        endcase
    end

endmodule

// File: rtl/irqr_top.sv
module irqr_top
    import irqr_pkg::*;
#(
    parameter int NUM_UNITS = 8,
    parameter int IDX_W     = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        req_valid,
    input  logic [31:0]                 cmd_lo,
    input  logic [31:0]                 cmd_hi,
    input  logic [IDX_W-1:0]            self_idx,
    input  logic [NUM_UNITS*DEST_W-1:0] unit_id,
    input  logic [NUM_UNITS*DEST_W-1:0] unit_ldest,
    input  logic [NUM_UNITS*FMT_W-1:0]  unit_fmt,
    input  logic [NUM_UNITS-1:0]        unit_en,
    output logic                        tgt_valid,
    output logic [NUM_UNITS-1:0]        tgt_mask,
    output logic [NUM_UNITS-1:0]        arb_mask,
    output logic [VEC_W-1:0]            tgt_vector,
    output logic [2:0]                  tgt_mode
);

    cmd_t cmd;
    assign cmd = decode_cmd(cmd_lo, cmd_hi);

    logic [NUM_UNITS-1:0] phys_hit;
    logic [NUM_UNITS-1:0] log_hit;
    logic [NUM_UNITS-1:0] phys_first;
    logic [NUM_UNITS-1:0] addressed;
    logic [NUM_UNITS-1:0] scoped;
    logic [NUM_UNITS-1:0] lowest;
    logic [NUM_UNITS-1:0] selected;
    logic                 arb_sync;

    irqr_unit_match #(.N(NUM_UNITS)) u_match (
        .dest       (cmd.dest),
        .unit_id    (unit_id),
        .unit_ldest (unit_ldest),
        .unit_fmt   (unit_fmt),
        .unit_en    (unit_en),
        .phys_hit   (phys_hit),
        .log_hit    (log_hit)
    );

    irqr_first_set #(.N(NUM_UNITS)) u_phys_first (
        .vec_in  (phys_hit),
        .vec_out (phys_first)
    );

    always_comb begin
        if (cmd.logical)
            addressed = log_hit;
        else if (cmd.dest == DEST_BCAST)
            addressed = unit_en;
        else
            addressed = phys_first;
    end

    irqr_scope #(.N(NUM_UNITS), .IDX_W(IDX_W)) u_scope (
        .sh        (cmd.sh),
        .self_idx  (self_idx),
        .unit_en   (unit_en),
        .addressed (addressed),
        .scoped    (scoped)
    );

    irqr_first_set #(.N(NUM_UNITS)) u_lp_first (
        .vec_in  (scoped),
        .vec_out (lowest)
    );

    assign selected = (cmd.mode == DM_LOWEST) ? lowest : scoped;
    assign arb_sync = is_arb_sync(cmd);

    always_ff @(posedge clk) begin
        if (rst) begin
            tgt_valid  <= 1'b0;
            tgt_mask   <= '0;
            arb_mask   <= '0;
            tgt_vector <= '0;
            tgt_mode   <= '0;
        end else begin
            tgt_valid <= req_valid;
            if (req_valid) begin
                tgt_mask   <= arb_sync ? '0 : selected;
                arb_mask   <= arb_sync ? selected : '0;
                tgt_vector <= cmd.vec;
                tgt_mode   <= cmd.mode;
            end
        end
    end

endmodule

// File: rtl/irqr_chk.sv
module irqr_chk
    import irqr_pkg::*;
#(
    parameter int N = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic [31:0]      cmd_lo,
    input logic [31:0]      cmd_hi,
    input logic [N-1:0]     unit_en,
    input logic             tgt_valid,
    input logic [N-1:0]     tgt_mask,
    input logic [N-1:0]     arb_mask,
    input logic [VEC_W-1:0] tgt_vector,
    input logic [2:0]       tgt_mode
);

    cmd_t c;
    assign c = decode_cmd(cmd_lo, cmd_hi);

    assert_strobe_R11: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> tgt_valid);

    assert_idle_R11: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !tgt_valid);

    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> ($stable(tgt_mask) && $stable(arb_mask) && $stable(tgt_vector)));

    assert_fields_R1: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (tgt_vector == $past(c.vec) && tgt_mode == $past(c.mode)));

    assert_phys_single_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && c.sh == SH_NONE && !c.logical && c.dest != DEST_BCAST)
        |=> ($countones(tgt_mask | arb_mask) <= 1));

    assert_self_only_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && c.sh == SH_SELF) |=> ($countones(tgt_mask | arb_mask) <= 1));

    assert_enabled_only_R8: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (((tgt_mask | arb_mask) & ~$past(unit_en)) == '0));

    assert_lowest_single_R9: assert property (@(posedge clk) disable iff (rst)
        (tgt_valid && tgt_mode == DM_LOWEST) |-> ($countones(tgt_mask) <= 1));

    assert_arb_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
        (tgt_valid && arb_mask != '0) |-> (tgt_mask == '0 && tgt_mode == DM_INIT));

endmodule

bind irqr_top irqr_chk #(.N(NUM_UNITS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .cmd_lo     (cmd_lo),
    .cmd_hi     (cmd_hi),
    .unit_en    (unit_en),
    .tgt_valid  (tgt_valid),
    .tgt_mask   (tgt_mask),
    .arb_mask   (arb_mask),
    .tgt_vector (tgt_vector),
    .tgt_mode   (tgt_mode)
);

// File: tb/sim_irqr_top.sv
`timescale 1ns/1ps
module sim_irqr_top;

    localparam int N  = 8;
    localparam int IW = 3;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           req_valid = 1'b0;
    logic [31:0]    cmd_lo = '0;
    logic [31:0]    cmd_hi = '0;
    logic [IW-1:0]  self_idx = '0;
    logic [N*8-1:0] unit_id = '0;
    logic [N*8-1:0] unit_ldest = '0;
    logic [N*4-1:0] unit_fmt = '0;
    logic [N-1:0]   unit_en = '0;
    logic           tgt_valid;
    logic [N-1:0]   tgt_mask;
    logic [N-1:0]   arb_mask;
    logic [7:0]     tgt_vector;
    logic [2:0]     tgt_mode;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [7:0] cid  [N];
    logic [7:0] cld  [N];
    logic [3:0] cfmt [N];
    logic [N-1:0] cen;
    int cself;

    always #2.5 clk = ~clk;

    irqr_top #(.NUM_UNITS(N)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid),
        .cmd_lo(cmd_lo), .cmd_hi(cmd_hi), .self_idx(self_idx),
        .unit_id(unit_id), .unit_ldest(unit_ldest), .unit_fmt(unit_fmt),
        .unit_en(unit_en), .tgt_valid(tgt_valid), .tgt_mask(tgt_mask),
        .arb_mask(arb_mask), .tgt_vector(tgt_vector), .tgt_mode(tgt_mode)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load_cfg(input int c);
        for (int i = 0; i < N; i++) begin
            cid[i]  = 8'((i * 37 + c * 11) & 255);
            cld[i]  = 8'((i * 53 + c * 29 + 1) & 255);
            cfmt[i] = (i % 3 == 0) ? 4'h0 : ((i % 3 == 1) ? 4'hF : 4'h8);
        end
        cid[5] = cid[2];
        case (c)
            0:       begin cen = 8'hDF; cself = 0; end
            1:       begin cen = 8'hFA; cself = 3; end
            default: begin cen = 8'hEF; cself = 4; end
        endcase
        for (int i = 0; i < N; i++) begin
            unit_id[i*8 +: 8]    = cid[i];
            unit_ldest[i*8 +: 8] = cld[i];
            unit_fmt[i*4 +: 4]   = cfmt[i];
        end
        unit_en  = cen;
        self_idx = IW'(cself);
    endtask

    // dsel: 0 fixed, 1 lowest priority, 2 INIT not de-assert, 3 INIT de-assert
    task automatic model(input int dest, input int lm, input int sh, input int dsel,
                         output logic [N-1:0] tm, output logic [N-1:0] am);
        logic [N-1:0] m;
        logic [N-1:0] lo;
        logic found;
        m = '0;
        case (sh)
            0: begin
                if (lm == 0) begin
                    if (dest == 255) m = cen;
                    else begin
                        found = 1'b0;
                        for (int i = 0; i < N; i++)
                            if (!found && cen[i] && cid[i] == 8'(dest)) begin
                                m[i] = 1'b1; found = 1'b1;
                            end
                    end
                end else begin
                    for (int i = 0; i < N; i++) begin
                        if (cen[i] && cfmt[i] == 4'hF && ((8'(dest) & cld[i]) != 0)) m[i] = 1'b1;
                        if (cen[i] && cfmt[i] == 4'h0 && (dest / 16) == int'(cld[i][7:4])
                            && ((dest % 16) & int'(cld[i][3:0])) != 0) m[i] = 1'b1;
                    end
                end
            end
            1: if (cen[cself]) m[cself] = 1'b1;
            2: m = cen;
            default: begin m = cen; m[cself] = 1'b0; end
        endcase
        if (dsel == 1) begin
            lo = '0; found = 1'b0;
            for (int i = 0; i < N; i++)
                if (!found && m[i]) begin lo[i] = 1'b1; found = 1'b1; end
            m = lo;
        end
        if (dsel == 3) begin tm = '0; am = m; end
        else begin tm = m; am = '0; end
    endtask

    initial begin
        logic [N-1:0] etm, eam, ptm, pam;
        logic [2:0] mode;
        logic [7:0] vec;
        logic lvl, trg;
        string tag;
        repeat (3) @(negedge clk);
        check(tgt_valid === 1'b0 && tgt_mask === '0 && arb_mask === '0, "R11 reset",
              {tgt_valid, tgt_mask, arb_mask}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(tgt_valid === 1'b0, "R11 idle after reset", 32'(tgt_valid), 0);

        ptm = '0; pam = '0;
        for (int c = 0; c < 3; c++) begin
            load_cfg(c);
            for (int dest = 0; dest < 256; dest++)
            for (int lm = 0; lm < 2; lm++)
            for (int sh = 0; sh < 4; sh++)
            for (int dsel = 0; dsel < 4; dsel++) begin
                mode = (dsel == 0) ? 3'd0 : ((dsel == 1) ? 3'd1 : 3'd5);
                lvl  = (dsel == 3) ? 1'b0 : ((dsel == 2) ? 1'(dest & 1) : 1'b1);
                trg  = (dsel == 3) ? 1'b1 : 1'b0;
                vec  = 8'(dest ^ 8'h5A ^ (sh * 16));
                cmd_lo = {12'(dest * 3 + c), 2'(sh), 2'(dest >> 2), trg, lvl,
                          2'(dest >> 4), 1'(lm), mode, vec};
                cmd_hi = {8'(dest), 24'(dest * 70001 + sh)};
                req_valid = 1'b1;
                model(dest, lm, sh, dsel, etm, eam);
                @(negedge clk);
                if (dsel == 3)           tag = "R10";
                else if (dsel == 1)      tag = "R9";
                else if (sh != 0)        tag = "R7 R8";
                else if (lm == 1)        tag = "R4 R5 R6 R8";
                else if (dest == 255)    tag = "R2 R8";
                else                     tag = "R3";
                check(tgt_valid === 1'b1 && tgt_mask === etm && arb_mask === eam, tag,
                      {15'd0, tgt_valid, tgt_mask, arb_mask}, {15'd0, 1'b1, etm, eam});
                check(tgt_vector === vec && tgt_mode === mode, "R1 fields",
                      {21'd0, tgt_mode, tgt_vector}, {21'd0, mode, vec});
                ptm = etm; pam = eam;
            end
        end

        req_valid = 1'b0;
        cmd_lo = 32'hFFFF_FFFF;
        cmd_hi = 32'hFFFF_FFFF;
        unit_en = '1;
        @(negedge clk);
        check(tgt_valid === 1'b0, "R11 strobe drops", 32'(tgt_valid), 0);
        check(tgt_mask === ptm && arb_mask === pam, "R11 hold",
              {tgt_mask, arb_mask}, {ptm, pam});
        @(negedge clk);
        check(tgt_valid === 1'b0 && tgt_mask === ptm, "R11 hold second cycle",
              {tgt_valid, tgt_mask}, {1'b0, ptm});

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R11 actual=%h expected=%h", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule